// File: doc/BRIEF.md
# Section Address Translator with Lookup Buffer

This block turns 32-bit virtual addresses from the core into physical addresses. Virtual space is cut into 1 MB sections. One table of section descriptors sits in memory, and its start address comes from a programmable base register. The top twelve address bits pick the descriptor. A small fully associative lookup buffer keeps recent translations. A request that hits is answered in the same cycle it is presented. A request that misses starts one single-word read on a memory read port and waits until the descriptor comes back.

Software writes the table base first. It then sets the enable bit of the control register with a read-modify-write. While the enable bit is clear, every address passes through unchanged and memory is never read. The buffer is emptied at reset, on every write to the base register, and on a pulse of the flush input. A descriptor that is not a section produces a fault response and is never kept in the buffer.

Top module: `sect_mmu`

## Requirements
- R1: With the enable bit (control register bit 0) clear, an accepted request gets `rsp_valid` in the same cycle with `rsp_pa` equal to `req_va`, `rsp_fault` low, and no `mem_req`.
- R2: With translation on, a request that misses raises `mem_req` for exactly one cycle, in the cycle the request is accepted, with `mem_addr` = table base + 4 × `req_va[31:20]`.
- R3: A returned descriptor whose bits [1:0] are 2'b10 is a section: in the cycle `mem_rvalid` is high the block raises `rsp_valid` with `rsp_pa` = {descriptor[31:20], va[19:0]} and `rsp_fault` low, and it stores the translation.
- R4: A descriptor with any other value in bits [1:0] gives `rsp_valid` with `rsp_fault` high and `rsp_pa` zero, and nothing is stored, so a repeat of the same access walks again.
- R5: A request whose region is already held is answered in the same cycle from the buffer, with no memory read.
- R6: The buffer holds 8 regions tagged by `va[31:20]` and replaces them in round-robin order. The ninth distinct region evicts the oldest one, which then misses again.
- R7: A `tlb_flush` pulse or any write to the base register empties the buffer at the next edge. If either comes while a walk is in flight, the result of that walk is returned but not stored.
- R8: Only one walk is in flight at a time. `req_ready` is low from the cycle after `mem_req` up to and including the cycle in which the descriptor returns.
- R9: After reset the buffer is empty, translation is off, the base register reads 0 and `req_ready` is high.
- R10: `cfg_rdata` shows the base register when `cfg_sel` is 1. When `cfg_sel` is 0 it shows the control register, with the enable in bit 0 and zeros elsewhere. A write with `cfg_we` updates the selected register at the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 1 | Register select: 0 control, 1 table base |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for the selected register |
| tlb_flush | input | 1 | Pulse that empties the lookup buffer |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block can accept a request this cycle |
| req_va | input | 32 | Virtual address |
| rsp_valid | output | 1 | Translation result present |
| rsp_pa | output | 32 | Physical address (zero on fault) |
| rsp_fault | output | 1 | Translation fault |
| mem_req | output | 1 | Descriptor read request, one cycle |
| mem_addr | output | 32 | Descriptor byte address |
| mem_rvalid | input | 1 | Descriptor read data valid |
| mem_rdata | input | 32 | Descriptor word |

## Verification
The bench targets a flush or base write landing while a walk is in flight. A design that ignored this would keep a stale translation, which would then hit without a memory read. It fills all eight slots and adds a ninth region, so a wrong replacement pointer shows up as a missing or extra walk on the next accesses. Fault descriptors are repeated to catch a design that keeps them and answers the second access from the buffer. A request is held high through a walk, and the translation is turned off while the buffer still holds entries. These expose a block that accepts work during a walk, or one that still translates when disabled.

// File: rtl/sect_mmu_pkg.sv
package sect_mmu_pkg;
   typedef enum logic {
      WALK_IDLE = 1'b0,
      WALK_WAIT = 1'b1
   } walk_st_e;

   localparam logic       SEL_CTRL   = 1'b0;
   localparam logic       SEL_BASE   = 1'b1;
   localparam int         EN_BIT     = 0;
   localparam logic [1:0] DESC_SECT  = 2'b10;
endpackage

// File: rtl/sect_mmu_regs.sv
module sect_mmu_regs
   import sect_mmu_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic              cfg_sel,
   input  logic [ADDR_W-1:0] cfg_wdata,
   output logic [ADDR_W-1:0] cfg_rdata,
   output logic              xlat_en,
   output logic [ADDR_W-1:0] tbl_base,
   output logic              base_wr
);
   logic              en_q;
   logic [ADDR_W-1:0] base_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q   <= 1'b0;
         base_q <= '0;
      end else if (cfg_we) begin
         if (cfg_sel == SEL_BASE) base_q <= cfg_wdata;
         else                     en_q   <= cfg_wdata[EN_BIT];
      end
   end

   always_comb begin
      cfg_rdata = '0;
      if (cfg_sel == SEL_BASE) cfg_rdata = base_q;
      else                     cfg_rdata[EN_BIT] = en_q;
   end

   assign xlat_en  = en_q;
   assign tbl_base = base_q;
   assign base_wr  = cfg_we && (cfg_sel == SEL_BASE);
endmodule

// File: rtl/sect_mmu_tlb.sv
module sect_mmu_tlb #(
   parameter int TAG_W = 12,
   parameter int DEPTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [TAG_W-1:0] lk_tag,
   output logic             lk_hit,
   output logic [TAG_W-1:0] lk_ppn,
   output logic [DEPTH-1:0] hit_vec,
   output logic [DEPTH-1:0] valid_vec,
   input  logic             flush,
   input  logic             fill,
   input  logic [TAG_W-1:0] fill_tag,
   input  logic [TAG_W-1:0] fill_ppn
);
   localparam int PTR_W = $clog2(DEPTH);
   localparam bit POW2  = (DEPTH == (1 << PTR_W));

   logic [TAG_W-1:0] tag_q [DEPTH];
   logic [TAG_W-1:0] ppn_q [DEPTH];
   logic [DEPTH-1:0] vld_q;
   logic [PTR_W-1:0] ptr_q;
   logic [PTR_W-1:0] ptr_nxt;
   logic             do_fill;

   assign do_fill = fill && !flush;

   generate
      for (genvar i = 0; i < DEPTH; i++) begin : g_slot
         assign hit_vec[i] = vld_q[i] && (tag_q[i] == lk_tag);

         always_ff @(posedge clk) begin
            if (do_fill && (ptr_q == PTR_W'(i))) begin
               tag_q[i] <= fill_tag;
               ppn_q[i] <= fill_ppn;
            end
         end

         always_ff @(posedge clk) begin
            if (!rst_n || flush)                          vld_q[i] <= 1'b0;
            else if (do_fill && (ptr_q == PTR_W'(i)))     vld_q[i] <= 1'b1;
         end
      end

      if (POW2) begin : g_wrap_free
         assign ptr_nxt = ptr_q + 1'b1;
      end else begin : g_wrap_cmp
         assign ptr_nxt = (ptr_q == PTR_W'(DEPTH - 1)) ? '0 : ptr_q + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)       ptr_q <= '0;
      else if (do_fill) ptr_q <= ptr_nxt;
   end

   always_comb begin
      lk_ppn = '0;
      for (int i = 0; i < DEPTH; i++) begin
         if (hit_vec[i]) lk_ppn = lk_ppn | ppn_q[i];
      end
   end

   assign lk_hit    = |hit_vec;
   assign valid_vec = vld_q;
endmodule

// File: rtl/sect_mmu_walker.sv
module sect_mmu_walker
   import sect_mmu_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int SECT_W = 20
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     start,
   input  logic [ADDR_W-1:0]        start_va,
   input  logic [ADDR_W-1:0]        tbl_base,
   input  logic                     kill,
   output logic                     busy,
   output logic                     mem_req,
   output logic [ADDR_W-1:0]        mem_addr,
   input  logic                     mem_rvalid,
   input  logic [ADDR_W-1:0]        mem_rdata,
   output logic                     done,
   output logic                     done_fault,
   output logic [ADDR_W-1:0]        done_pa,
   output logic                     fill,
   output logic [ADDR_W-SECT_W-1:0] fill_tag,
   output logic [ADDR_W-SECT_W-1:0] fill_ppn
);
   localparam int IDX_W = ADDR_W - SECT_W;

   walk_st_e          st_q;
   logic [ADDR_W-1:0] va_q;
   logic              stale_q;
   logic              sect_ok;
   logic              desc_unused;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q    <= WALK_IDLE;
         va_q    <= '0;
         stale_q <= 1'b0;
      end else begin
         case (st_q)
            WALK_IDLE: if (start) begin
               st_q    <= WALK_WAIT;
               va_q    <= start_va;
               stale_q <= 1'b0;
            end
            WALK_WAIT: begin
               if (mem_rvalid) st_q    <= WALK_IDLE;
               else if (kill)  stale_q <= 1'b1;
            end
            default: st_q <= WALK_IDLE;
         endcase
      end
   end

   assign busy     = (st_q == WALK_WAIT);
   assign mem_req  = start;
   assign mem_addr = tbl_base + ADDR_W'({start_va[ADDR_W-1:SECT_W], 2'b00});

   assign sect_ok    = (mem_rdata[1:0] == DESC_SECT);
   assign done       = busy && mem_rvalid;
   assign done_fault = !sect_ok;
   assign done_pa    = sect_ok ? {mem_rdata[ADDR_W-1:SECT_W], va_q[SECT_W-1:0]} : '0;
   assign fill       = done && sect_ok && !stale_q && !kill;
   assign fill_tag   = va_q[ADDR_W-1:SECT_W];
   assign fill_ppn   = mem_rdata[ADDR_W-1:SECT_W];

   assign desc_unused = ^{mem_rdata[SECT_W-1:2], IDX_W[0]};
endmodule

// File: rtl/sect_mmu.sv
module sect_mmu
   import sect_mmu_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int SECT_W    = 20,
   parameter int TLB_DEPTH = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic              cfg_sel,
   input  logic [ADDR_W-1:0] cfg_wdata,
   output logic [ADDR_W-1:0] cfg_rdata,
   input  logic              tlb_flush,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_va,
   output logic              rsp_valid,
   output logic [ADDR_W-1:0] rsp_pa,
   output logic              rsp_fault,
   output logic              mem_req,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic              mem_rvalid,
   input  logic [ADDR_W-1:0] mem_rdata
);
   localparam int IDX_W = ADDR_W - SECT_W;

   generate
      if (SECT_W < 2 || SECT_W >= ADDR_W) begin : g_bad_sect
         $error("sect_mmu: SECT_W must lie in [2, ADDR_W-1]");
      end
      if (TLB_DEPTH < 2) begin : g_bad_depth
         $error("sect_mmu: TLB_DEPTH must be at least 2");
      end
      if (EN_BIT >= ADDR_W) begin : g_bad_en
         $error("sect_mmu: enable bit outside register");
      end
   endgenerate

   logic                 xlat_en;
   logic [ADDR_W-1:0]    tbl_base;
   logic                 base_wr;
   logic                 flush_all;
   logic                 tlb_hit;
   logic [IDX_W-1:0]     tlb_ppn;
   logic [TLB_DEPTH-1:0] tlb_hit_vec;
   logic [TLB_DEPTH-1:0] tlb_valid_vec;
   logic                 walk_busy;
   logic                 walk_start;
   logic                 walk_done;
   logic                 walk_fault;
   logic [ADDR_W-1:0]    walk_pa;
   logic                 walk_fill;
   logic [IDX_W-1:0]     walk_tag;
   logic [IDX_W-1:0]     walk_ppn;
   logic                 accept;

   sect_mmu_regs #(.ADDR_W(ADDR_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_we    (cfg_we),
      .cfg_sel   (cfg_sel),
      .cfg_wdata (cfg_wdata),
      .cfg_rdata (cfg_rdata),
      .xlat_en   (xlat_en),
      .tbl_base  (tbl_base),
      .base_wr   (base_wr)
   );

   assign flush_all  = tlb_flush || base_wr;
   assign accept     = req_valid && !walk_busy;
   assign walk_start = accept && xlat_en && !tlb_hit;

   sect_mmu_tlb #(.TAG_W(IDX_W), .DEPTH(TLB_DEPTH)) u_tlb (
      .clk       (clk),
      .rst_n     (rst_n),
      .lk_tag    (req_va[ADDR_W-1:SECT_W]),
      .lk_hit    (tlb_hit),
      .lk_ppn    (tlb_ppn),
      .hit_vec   (tlb_hit_vec),
      .valid_vec (tlb_valid_vec),
      .flush     (flush_all),
      .fill      (walk_fill),
      .fill_tag  (walk_tag),
      .fill_ppn  (walk_ppn)
   );

   sect_mmu_walker #(.ADDR_W(ADDR_W), .SECT_W(SECT_W)) u_walk (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (walk_start),
      .start_va   (req_va),
      .tbl_base   (tbl_base),
      .kill       (flush_all),
      .busy       (walk_busy),
      .mem_req    (mem_req),
      .mem_addr   (mem_addr),
      .mem_rvalid (mem_rvalid),
      .mem_rdata  (mem_rdata),
      .done       (walk_done),
      .done_fault (walk_fault),
      .done_pa    (walk_pa),
      .fill       (walk_fill),
      .fill_tag   (walk_tag),
      .fill_ppn   (walk_ppn)
   );

   assign req_ready = !walk_busy;
   assign rsp_valid = walk_done || (accept && (!xlat_en || tlb_hit));
   assign rsp_fault = walk_done && walk_fault;

   always_comb begin
      if (walk_done)     rsp_pa = walk_pa;
      else if (!xlat_en) rsp_pa = req_va;
      else               rsp_pa = {tlb_ppn, req_va[SECT_W-1:0]};
   end
endmodule

// File: rtl/sect_mmu_chk.sv
module sect_mmu_chk #(
   parameter int DEPTH = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             req_ready,
   input logic             rsp_valid,
   input logic             rsp_fault,
   input logic             mem_req,
   input logic             mem_rvalid,
   input logic             tlb_flush,
   input logic             xlat_en,
   input logic [DEPTH-1:0] hit_vec,
   input logic [DEPTH-1:0] valid_vec
);
   AST_OFF_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
      !xlat_en |-> !mem_req);                                   // R1
   AST_READ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |=> !mem_req);                                    // R2
   AST_RETURN_ANSWERS: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rvalid && !req_ready) |-> rsp_valid);                // R3
   AST_FAULT_IN_RSP: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_fault |-> rsp_valid);                                 // R4
   AST_MISS_NO_RSP: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> !rsp_valid);                                  // R5
   AST_HIT_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit_vec));                                       // R6
   AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      tlb_flush |=> (valid_vec == '0));                         // R7
   AST_WALK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |=> !req_ready);                                  // R8
endmodule

bind sect_mmu sect_mmu_chk #(.DEPTH(TLB_DEPTH)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_ready  (req_ready),
   .rsp_valid  (rsp_valid),
   .rsp_fault  (rsp_fault),
   .mem_req    (mem_req),
   .mem_rvalid (mem_rvalid),
   .tlb_flush  (tlb_flush),
   .xlat_en    (xlat_en),
   .hit_vec    (tlb_hit_vec),
   .valid_vec  (tlb_valid_vec)
);

// File: tb/sect_mmu_test.sv
module sect_mmu_test;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        cfg_we, cfg_sel, tlb_flush, req_valid, mem_rvalid;
   logic [31:0] cfg_wdata, req_va, mem_rdata;
   logic [31:0] cfg_rdata, rsp_pa, mem_addr;
   logic        req_ready, rsp_valid, rsp_fault, mem_req;

   always #(CLK_PERIOD / 2) clk = ~clk;

   sect_mmu uut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .tlb_flush(tlb_flush),
      .req_valid(req_valid), .req_ready(req_ready), .req_va(req_va),
      .rsp_valid(rsp_valid), .rsp_pa(rsp_pa), .rsp_fault(rsp_fault),
      .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
      .mem_rdata(mem_rdata)
   );

   int checks = 0;
   int fails  = 0;
   bit finished = 0;

   // stimulus registers
   bit          d_req, d_flush, d_we, d_sel;
   logic [31:0] d_va, d_wdata;
   string       cur_tag = "";

   // reference model
   logic [31:0] m_base;
   bit          m_en;
   bit          m_tv [8];
   logic [11:0] m_tag [8];
   logic [11:0] m_ppn [8];
   int          m_ptr;
   bit          m_wait, m_stale;
   logic [31:0] m_va;
   // memory model
   bit          mb;
   int          mc, lat;
   logic [31:0] ma;

   function automatic logic [31:0] desc_fn(logic [31:0] a);
      logic [11:0] i = a[13:2];
      if (i[3:0] == 4'hF) return {i ^ 12'h5A3, 18'h0, 2'b01};
      return {i ^ 12'h5A3, 18'h0, 2'b10};
   endfunction

   function automatic string tg(string dflt);
      return (cur_tag != "") ? cur_tag : dflt;
   endfunction

   task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic model_reset();
      m_base = 0; m_en = 0; m_ptr = 0; m_wait = 0; m_stale = 0; m_va = 0;
      for (int i = 0; i < 8; i++) m_tv[i] = 0;
      mb = 0; mc = 0; ma = 0;
   endtask

   task automatic step();
      bit          e_ready, e_rsp, e_fault, e_mreq, hit, wdone, ok, flushnow;
      logic [31:0] e_pa, e_maddr, e_rdata, dsc;
      int          hidx;
      @(negedge clk);
      req_valid = d_req; req_va = d_va; tlb_flush = d_flush;
      cfg_we = d_we; cfg_sel = d_sel; cfg_wdata = d_wdata;
      mem_rvalid = mb && (mc == 0);
      mem_rdata  = mem_rvalid ? desc_fn(ma) : 32'hDEAD_BEEF;
      #1;
      e_ready = !m_wait; e_rsp = 0; e_fault = 0; e_mreq = 0;
      e_pa = 0; e_maddr = 0; hit = 0; hidx = 0; ok = 0; dsc = 0;
      if (!m_wait && d_req) begin
         if (!m_en) begin
            e_rsp = 1; e_pa = d_va;
         end else begin
            for (int i = 0; i < 8; i++)
               if (m_tv[i] && m_tag[i] == d_va[31:20]) begin hit = 1; hidx = i; end
            if (hit) begin
               e_rsp = 1; e_pa = {m_ppn[hidx], d_va[19:0]};
            end else begin
               e_mreq = 1; e_maddr = m_base + {18'h0, d_va[31:20], 2'b00};
            end
         end
      end
      wdone = m_wait && mem_rvalid;
      if (wdone) begin
         dsc = mem_rdata; ok = (dsc[1:0] == 2'b10);
         e_rsp = 1; e_fault = !ok; e_pa = ok ? {dsc[31:20], m_va[19:0]} : 32'h0;
      end
      e_rdata = d_sel ? m_base : {31'h0, m_en};

      chk(tg("R8"), "req_ready", {31'h0, req_ready}, {31'h0, e_ready});
      chk(tg(wdone ? "R3" : (!m_en ? "R1" : "R5")), "rsp_valid",
          {31'h0, rsp_valid}, {31'h0, e_rsp});
      if (e_rsp) begin
         chk(tg(wdone ? (ok ? "R3" : "R4") : (!m_en ? "R1" : "R5")), "rsp_pa", rsp_pa, e_pa);
         chk(tg("R4"), "rsp_fault", {31'h0, rsp_fault}, {31'h0, e_fault});
      end
      chk(tg(!m_en ? "R1" : (hit ? "R6" : "R2")), "mem_req",
          {31'h0, mem_req}, {31'h0, e_mreq});
      if (e_mreq) chk(tg("R2"), "mem_addr", mem_addr, e_maddr);
      chk(tg("R10"), "cfg_rdata", cfg_rdata, e_rdata);

      // advance the model to the state after this edge
      flushnow = d_flush || (d_we && d_sel);
      if (wdone && ok && !m_stale && !flushnow) begin
         m_tag[m_ptr] = m_va[31:20]; m_ppn[m_ptr] = dsc[31:20];
         m_tv[m_ptr] = 1; m_ptr = (m_ptr + 1) % 8;
      end
      if (flushnow) for (int i = 0; i < 8; i++) m_tv[i] = 0;
      if (wdone) m_wait = 0;
      else if (m_wait && flushnow) m_stale = 1;
      if (e_mreq) begin m_wait = 1; m_va = d_va; m_stale = 0; end
      if (d_we) begin
         if (d_sel) m_base = d_wdata; else m_en = d_wdata[0];
      end
      if (mem_rvalid) mb = 0;
      else if (mb && mc > 0) mc--;
      if (e_mreq) begin mb = 1; mc = lat; ma = e_maddr; end
   endtask

   task automatic access(logic [31:0] va, int l, bit hold);
      lat = l; d_req = 1; d_va = va;
      step();
      d_req = hold;
      while (m_wait) step();
      d_req = 0;
   endtask

   task automatic wr(bit sel, logic [31:0] data);
      d_we = 1; d_sel = sel; d_wdata = data;
      step();
      d_we = 0;
   endtask

   initial begin
      #(CLK_PERIOD * 50000);
      if (!finished) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [31:0] rd;
      rst_n = 0; cfg_we = 0; cfg_sel = 0; cfg_wdata = 0; tlb_flush = 0;
      req_valid = 0; req_va = 0; mem_rvalid = 0; mem_rdata = 0;
      d_req = 0; d_flush = 0; d_we = 0; d_sel = 0; d_va = 0; d_wdata = 0; lat = 0;
      model_reset();
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1;

      // R9: reset state, both registers read back
      cur_tag = "R9";
      d_sel = 0; step();
      d_sel = 1; step();
      d_sel = 0; cur_tag = "";

      // R1: identity mapping while disabled
      access(32'h1234_5678, 0, 0);
      access(32'hFFFF_FFFF, 0, 0);
      access(32'h00F0_0004, 0, 0);

      // R10: base write, then read-modify-write of the enable bit
      wr(1, 32'h0040_0000);
      d_sel = 0; step(); rd = cfg_rdata;
      wr(0, rd | 32'h1);
      step();

      // R2 R3: miss with latency 2, R5: hit in another offset of that region
      access(32'h1234_5678, 2, 0);
      access(32'h123F_0001, 0, 0);
      // R4: fault descriptor, repeated to prove nothing is kept
      cur_tag = "R4";
      access(32'h00F0_0000, 1, 0);
      access(32'h00F8_8888, 0, 0);
      cur_tag = "";

      // R6: fill all slots, then evict the oldest
      for (int k = 0; k < 7; k++) access({12'h010 + 12'(k), 20'h0_0AB0}, k % 3, 0);
      for (int k = 0; k < 7; k++) access({12'h010 + 12'(k), 20'h5_0000}, 0, 0);
      cur_tag = "R6";
      access(32'h0170_0000, 1, 0);
      access(32'h1230_0000, 0, 0);
      access(32'h0115_5555, 0, 0);
      cur_tag = "";

      // R7: flush pulse empties the buffer
      d_flush = 1; step(); d_flush = 0;
      cur_tag = "R7";
      access(32'h0115_5555, 0, 0);
      cur_tag = "";
      // R7: flush during a walk, result returned but not stored
      lat = 2; d_req = 1; d_va = 32'h0220_0000; step();
      d_req = 0; d_flush = 1; step(); d_flush = 0;
      while (m_wait) step();
      cur_tag = "R7";
      access(32'h0220_0010, 0, 0);
      cur_tag = "";
      // R7: base write empties the buffer
      wr(1, 32'h0000_0000);
      cur_tag = "R7";
      access(32'h0220_0020, 0, 0);
      cur_tag = "";

      // R8: request held high through the walk
      cur_tag = "R8";
      access(32'h0330_0000, 3, 1);
      step();
      cur_tag = "";

      // R1: disabled again while entries are held
      wr(0, 32'h0);
      access(32'h0330_0040, 0, 0);
      step();

      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule